// File: doc/BRIEF.md
# Host Interrupt Status Collector with Write-One-to-Clear

This block gathers the host-side interrupt events of a bus-mastering data mover into one status word and one interrupt line. It takes five event pulses: read transfer done, write transfer done, master abort, target abort, and a mailbox event. Each pulse sets its own sticky status bit. The line `irq_o` is high while any set bit has its effective enable on. Software reads the status word to learn which source fired. It clears a bit by writing a one to that bit position. Writing a zero to a position leaves the bit as it was.

There are only three enable bits: mailbox, write-complete and read-complete. The two abort sources have no enable of their own. They count as enabled whenever either transfer-complete enable is on. The bus interface and the mailbox compare logic sit outside this block. The block offers a flat 32-bit register port with a one-bit register select.

Top module: `irqc_top`

## Requirements
- R1: While `rst_n` is low, every status bit and every enable bit is 0. `irq_o` is 0, and both registers read as 0.
- R2: An event pulse sets its status bit on the next rising clock edge. The bit positions in the status register (select 0) are: mailbox 17, write-complete 18, read-complete 19, master abort 20, target abort 21. A set bit stays set until it is cleared.
- R3: A write to select 0 clears each status bit at a position where `reg_wdata` holds 1. Bits whose position holds 0 keep their value. Bits of the status register outside 21:17 always read 0.
- R4: If an event pulse and a write-one-to-clear of the same bit happen in the same cycle, the bit is set after the edge.
- R5: The enable register is at select 1. Bit 0 enables the mailbox, bit 1 enables write-complete, and bit 2 enables read-complete. A write to it loads those three bits. Its other bits always read 0.
- R6: `irq_o` is the OR over all sources of the status bit ANDed with its effective enable. It stays high until every set, enabled bit is cleared or disabled.
- R7: The master-abort and target-abort bits raise `irq_o` only while enable bit 1 or enable bit 2 is set.
- R8: A status bit is recorded even when its source is disabled. Such a bit does not raise `irq_o` until its source is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| ev_mbox | input | 1 | Mailbox event pulse |
| ev_wr_done | input | 1 | Write transfer complete pulse |
| ev_rd_done | input | 1 | Read transfer complete pulse |
| ev_mabort | input | 1 | Master abort pulse |
| ev_tabort | input | 1 | Target abort pulse |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
An event pulse and a software clear of the same status bit can land on the same clock edge. This collision is the case most likely to lose an interrupt. The bench forces it in directed steps on the read-complete and target-abort bits. The random phase also produces it often, because it drives event pulses and clear masks independently on every cycle. After each edge, a bench model in which setting wins over clearing judges the status word that is read back and the level of `irq_o`. The same cycles also cover abort bits under every combination of the transfer enables.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_SRC  = 5;
  localparam int EN_W     = 3;
  localparam int STAT_LSB = 17;
  localparam int STAT_MSB = STAT_LSB + NUM_SRC - 1;

  // source index order inside the status field
  localparam int SRC_MBOX = 0;
  localparam int SRC_WR   = 1;
  localparam int SRC_RD   = 2;
  localparam int SRC_MABT = 3;
  localparam int SRC_TABT = 4;

  // enable-register bit positions
  localparam int EN_MBOX = 0;
  localparam int EN_WR   = 1;
  localparam int EN_RD   = 2;

  // map the three stored enables onto the five sources
  function automatic logic [NUM_SRC-1:0] eff_enable(input logic [EN_W-1:0] en);
    logic abort_on;
    abort_on = en[EN_WR] | en[EN_RD];
    eff_enable = '0;
    eff_enable[SRC_MBOX] = en[EN_MBOX];
    eff_enable[SRC_WR]   = en[EN_WR];
    eff_enable[SRC_RD]   = en[EN_RD];
    eff_enable[SRC_MABT] = abort_on;
    eff_enable[SRC_TABT] = abort_on;
  endfunction

  // next value of one sticky bit: a set beats a clear
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    sticky_next = set | (q & ~clr);
  endfunction
endpackage

// File: rtl/irqc_bit_latch.sv
module irqc_bit_latch
  import irqc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= sticky_next(q_o, set_i, clr_i);
  end

  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
  assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/irqc_combine.sv
module irqc_combine
  import irqc_pkg::*;
(
  input  logic [NUM_SRC-1:0] stat_i,
  input  logic [EN_W-1:0]    en_i,
  output logic [NUM_SRC-1:0] active_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] eff_en;

  always_comb begin
    eff_en   = eff_enable(en_i);
    active_o = stat_i & eff_en;
    irq_o    = |active_o;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_mbox,
  input  logic              ev_wr_done,
  input  logic              ev_rd_done,
  input  logic              ev_mabort,
  input  logic              ev_tabort,
  output logic              irq_o
);
  logic [EN_W-1:0]    en_q;
  logic [NUM_SRC-1:0] ev_vec;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] active;
  logic               wr_stat;
  logic               wr_en;

  assign wr_stat = reg_wr && (reg_sel == 1'b0);
  assign wr_en   = reg_wr && (reg_sel == 1'b1);

  always_comb begin
    ev_vec           = '0;
    ev_vec[SRC_MBOX] = ev_mbox;
    ev_vec[SRC_WR]   = ev_wr_done;
    ev_vec[SRC_RD]   = ev_rd_done;
    ev_vec[SRC_MABT] = ev_mabort;
    ev_vec[SRC_TABT] = ev_tabort;
    clr_vec          = wr_stat ? reg_wdata[STAT_MSB:STAT_LSB] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= reg_wdata[EN_W-1:0];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irqc_bit_latch u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ev_vec[i]),
      .clr_i (clr_vec[i]),
      .q_o   (stat_q[i])
    );
  end

  irqc_combine u_comb (
    .stat_i   (stat_q),
    .en_i     (en_q),
    .active_o (active),
    .irq_o    (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == 1'b0) reg_rdata[STAT_MSB:STAT_LSB] = stat_q;
    else                 reg_rdata[EN_W-1:0]          = en_q;
  end

  assert_abort_autoen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q[SRC_MABT] || stat_q[SRC_TABT]) && (en_q[EN_WR] || en_q[EN_RD])) |-> irq_o);
  assert_no_status_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |-> !irq_o);
  assert_all_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o);
  assert_level_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !reg_wr) |=> irq_o);
  assert_en_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_q == $past(reg_wdata[EN_W-1:0])));
endmodule

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        ev_mbox, ev_wr_done, ev_rd_done, ev_mabort, ev_tabort;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  logic [4:0] m_stat;   // bit0 mbox .. bit4 target abort
  logic [2:0] m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_mbox(ev_mbox), .ev_wr_done(ev_wr_done), .ev_rd_done(ev_rd_done),
    .ev_mabort(ev_mabort), .ev_tabort(ev_tabort), .irq_o(irq_o)
  );

  // expected interrupt: each source counted if set and allowed
  function automatic logic exp_irq(input logic [4:0] s, input logic [2:0] e);
    logic ab;
    ab = e[1] || e[2];
    return (s[0] && e[0]) || (s[1] && e[1]) || (s[2] && e[2]) ||
           (s[3] && ab) || (s[4] && ab);
  endfunction

  function automatic logic [31:0] exp_status_word(input logic [4:0] s);
    logic [31:0] w;
    w = 32'h0;
    for (int k = 0; k < 5; k++) w[17+k] = s[k];
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic quiet_inputs();
    reg_wr = 1'b0; reg_wdata = 32'h0;
    ev_mbox = 0; ev_wr_done = 0; ev_rd_done = 0; ev_mabort = 0; ev_tabort = 0;
  endtask

  // called just after a falling edge
  task automatic check_all();
    quiet_inputs();
    chk("R6/R7/R8 irq", {31'b0, irq_o}, {31'b0, exp_irq(m_stat, m_en)});
    reg_sel = 1'b0; #1;
    chk("R2/R3/R4 status", reg_rdata, exp_status_word(m_stat));
    reg_sel = 1'b1; #1;
    chk("R5 enable", reg_rdata, {29'b0, m_en});
  endtask

  task automatic step(input logic wr, input logic sel, input logic [31:0] wd,
                      input logic [4:0] ev);
    logic [4:0] clr, nstat;
    logic [2:0] nen;
    reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    ev_mbox = ev[0]; ev_wr_done = ev[1]; ev_rd_done = ev[2];
    ev_mabort = ev[3]; ev_tabort = ev[4];
    clr   = (wr && !sel) ? wd[21:17] : 5'b0;
    nstat = ev | (m_stat & ~clr);
    nen   = (wr && sel) ? wd[2:0] : m_en;
    @(negedge clk);
    m_stat = nstat;
    m_en   = nen;
    check_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    quiet_inputs();
    repeat (2) @(negedge clk);
    m_stat = '0; m_en = '0;
    check_all();   // R1 under reset
    rst_n = 1'b1;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog expired, run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; reg_sel = 1'b0; m_stat = '0; m_en = '0;
    quiet_inputs();
    do_reset();                                     // R1

    // R8: events recorded while all enables are off, irq stays low
    step(1'b0, 1'b0, 32'h0, 5'b11111);
    // R5: only bits 2:0 load, others read 0
    step(1'b1, 1'b1, 32'hFFFF_FFF8, 5'b0);
    // R3: clear mailbox and write-complete only
    step(1'b1, 1'b0, 32'h0006_0000, 5'b0);
    // R7: only read-complete enabled -> aborts count
    step(1'b1, 1'b1, 32'h0000_0004, 5'b0);
    step(1'b1, 1'b0, 32'h0008_0000, 5'b0);          // clear rd, aborts keep irq
    // R6: clear master abort, target abort still holds irq
    step(1'b1, 1'b0, 32'h0010_0000, 5'b0);
    step(1'b1, 1'b0, 32'h0020_0000, 5'b0);          // now all clear, irq low
    // R4: event and clear of same bit in same cycle
    step(1'b1, 1'b0, 32'h0008_0000, 5'b00100);
    step(1'b1, 1'b0, 32'h0020_0000, 5'b10000);
    // R3: writing zeros leaves bits unchanged
    step(1'b1, 1'b0, 32'hFFC1_FFFF, 5'b0);
    // R7: abort with no transfer enable, only mailbox enabled
    step(1'b1, 1'b1, 32'h0000_0001, 5'b0);
    step(1'b1, 1'b0, 32'h0008_0000, 5'b0);          // only target abort left
    step(1'b1, 1'b1, 32'h0000_0002, 5'b0);          // write-complete enable

    for (int n = 0; n < N_RANDOM; n++) begin
      logic        wr, sel;
      logic [31:0] wd;
      logic [4:0]  ev;
      wr  = ($urandom_range(0, 2) == 0);
      sel = ($urandom_range(0, 3) == 0);
      wd  = $urandom();
      ev  = 5'($urandom()) & 5'($urandom());
      step(wr, sel, wd, ev);
    end

    do_reset();                                     // R1 after activity
    step(1'b0, 1'b0, 32'h0, 5'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule